// File: doc/BRIEF.md
# Routed Interrupt Controller with Rotating Priority

The block collects 64 interrupt inputs and sends each one to one of eight output lines. These lines are a normal interrupt, a fast interrupt and six auxiliary lines. Each source has a control byte in a 32-bit register window. The byte holds the source's enable bit, its trigger kind and its destination. A source can trigger on a high level, on a rising edge, on a falling edge or on either edge. Edge events are caught in sticky latches. Software reads these latches as two status words and clears a bit by writing 1 to it.

The normal output and the fast output each have an arbiter with its own priority register. A read of that register returns the number of the winning source and a valid flag. The read also counts as the grant of that source. In fixed mode the lowest pending number always wins. In rotating mode the search starts one place past the last granted source, so every pending source is served in turn. Software reaches all registers over a simple 32-bit bus with byte enables. Reads are combinational, and writes take effect at the clock edge.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every control byte reads 0, every output line is low, both priority registers read 0 and both status words read 0.
- R2: The control byte of source s sits at byte address 0x40+s. A write changes only the byte lanes whose byte enables are set, and a read of word 0x40+4k returns the bytes of sources 4k..4k+3, with the lowest-numbered source in bits 7:0.
- R3: When bits 6 and 5 of the control byte are both 0, the source is level-triggered. It is pending while its input is high and enable bit 3 is set, and this shows on its output line two clocks after the input changes.
- R4: Bit 5 selects a rising-edge trigger and bit 6 selects a falling-edge trigger. The edge latch is set three clocks after the input edge even while the source is disabled. Status word 0x80 holds sources 0..31 and word 0x84 holds sources 32..63, with bit n of each word belonging to source n mod 32.
- R5: Writing 1 to a status bit clears that latch, and writing 0 leaves the latch unchanged.
- R6: Bits 2:0 of the control byte route the source. Value 0 routes to the normal output, 1 to the fast output, and 2..7 to auxiliary lines 0..5. Each output line is high whenever at least one enabled pending source is routed to it.
- R7: Priority registers sit at 0x20 (normal) and 0x24 (fast). A read returns the winner in bits 5:0, the rotation flag in bit 6 and a valid flag in bit 7. The winner field is 0 when nothing is pending. With rotation off, the lowest-numbered pending source routed to that output wins.
- R8: Writing a priority register loads the rotation flag from bit 6 and the last-grant pointer from bits 5:0. A read that returns a valid winner records that winner as the last grant. With rotation on, the winner is the first pending source above the last grant, wrapping to the lowest pending source.
- R9: A latched edge on a disabled source drives no output. Setting the enable bit later makes the source pending without a new edge.
- R10: With bits 5 and 6 both set, the latch captures both rising and falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_in | input | 64 | Asynchronous interrupt inputs |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| aux_o | output | 6 | Auxiliary destination lines |

## Verification
The assertions assume that the two-stage synchronizer turns each input into a clean value, so the rise and fall they reason about are seen on the synchronized copy. They also assume that each bus strobe lasts exactly one clock, so a priority read records exactly one grant. The bench changes inputs and bus signals only on the falling clock edge and holds each strobe for a single cycle. It returns every input to low and clears every latch between vectors, so no source is left pending when the next case starts.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int CFG_EN_BIT   = 3;
    localparam int CFG_RISE_BIT = 5;
    localparam int CFG_FALL_BIT = 6;
    localparam int ROT_BIT      = 6;
    localparam int VALID_BIT    = 7;

    localparam logic [7:0] ADR_PRIO_NRM = 8'h20;
    localparam logic [7:0] ADR_PRIO_FST = 8'h24;
    localparam logic [7:0] ADR_CFG_LO   = 8'h40;
    localparam logic [7:0] ADR_STAT_LO  = 8'h80;

    typedef enum logic [2:0] {
        DST_NRM  = 3'd0,
        DST_FST  = 3'd1,
        DST_AUX0 = 3'd2
    } dest_e;
endpackage

// File: rtl/irq_route_src.sv
module irq_route_src
    import irq_route_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_i,
    input  logic [7:0] cfg_i,
    input  logic       clr_i,
    output logic       latch_o,
    output logic       pend_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   latch;
    } src_state_t;

    src_state_t st_d, st_q;
    logic cur, rise, fall, hit, edge_mode;

    always_comb begin
        st_d      = st_q;
        cur       = st_q.sync[SYNC_STAGES-1];
        rise      = cur & ~st_q.prev;
        fall      = ~cur & st_q.prev;
        hit       = (cfg_i[CFG_RISE_BIT] & rise) | (cfg_i[CFG_FALL_BIT] & fall);
        edge_mode = cfg_i[CFG_RISE_BIT] | cfg_i[CFG_FALL_BIT];
        st_d.sync  = {st_q.sync[SYNC_STAGES-2:0], raw_i};
        st_d.prev  = cur;
        st_d.latch = hit | (st_q.latch & ~clr_i);
        latch_o    = st_q.latch;
        pend_o     = cfg_i[CFG_EN_BIT] & (edge_mode ? st_q.latch : cur);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4 / R10: a selected edge always leaves the latch set
    a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> latch_o);

    // R5: write-1-to-clear with no new edge empties the latch
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !latch_o);
endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
    import irq_route_pkg::*;
#(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          wr_i,
    input  logic [IW:0]   wdata_i,
    input  logic          ack_i,
    output logic          valid_o,
    output logic [IW-1:0] win_o,
    output logic          rot_o
);
    typedef struct packed {
        logic          rot;
        logic [IW-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic [N-1:0] above, masked;

    function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
        logic [IW-1:0] idx;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) idx = IW'(i);
        end
        return idx;
    endfunction

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) above[i] = (IW'(i) > st_q.ptr);
        masked  = req_i & above;
        valid_o = |req_i;
        if (!valid_o)                 win_o = '0;
        else if (st_q.rot && |masked) win_o = lowest(masked);
        else                          win_o = lowest(req_i);
        rot_o = st_q.rot;
        if (wr_i) begin
            st_d.rot = wdata_i[IW];
            st_d.ptr = wdata_i[IW-1:0];
        end else if (ack_i && valid_o) begin
            st_d.ptr = win_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rot: 1'b0, ptr: {IW{1'b1}}};
        else        st_q <= st_d;
    end

    // R7: the reported winner is itself pending
    a_r7_win_pending: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> req_i[win_o]);

    // R7: fixed mode never skips a lower pending source
    a_r7_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !rot_o) |-> ((req_i & ((N'(1) << win_o) - N'(1))) == '0));

    // R8: rotating mode picks above the last grant when one is waiting there
    a_r8_rot_above: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_o && |masked) |-> (win_o > st_q.ptr));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NSRC        = 64,
    parameter int SYNC_STAGES = 2,
    parameter int NAUX        = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [7:0]      bus_addr,
    input  logic [3:0]      bus_be,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NSRC-1:0] src_in,
    output logic            irq_o,
    output logic            fiq_o,
    output logic [NAUX-1:0] aux_o
);
    localparam int IW     = $clog2(NSRC);
    localparam int NOUT   = NAUX + 2;
    localparam int NWORD  = NSRC / 4;
    localparam int WIW    = IW - 2;
    localparam int NSTAT  = NSRC / 32;
    localparam int NARB   = 2;

    typedef struct packed {
        logic [NSRC-1:0][7:0] cfg;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic            wr_en, rd_en, in_cfg;
    logic [WIW-1:0]  word_idx;
    logic [NSRC-1:0] clr_vec, latch_vec, pend_vec;
    logic [NOUT-1:0] line;
    logic [NOUT-1:0][NSRC-1:0] routed;

    logic [NARB-1:0]         arb_wr, arb_ack, arb_valid, arb_rot;
    logic [NARB-1:0][IW-1:0] arb_win;
    logic [NARB-1:0][7:0]    arb_adr;

    assign wr_en    = bus_en & bus_we;
    assign rd_en    = bus_en & ~bus_we;
    assign in_cfg   = (bus_addr >= ADR_CFG_LO) && (bus_addr < ADR_STAT_LO);
    assign word_idx = bus_addr[WIW+1:2];
    assign arb_adr[0] = ADR_PRIO_NRM;
    assign arb_adr[1] = ADR_PRIO_FST;

    // configuration bytes, byte-lane writes
    always_comb begin
        st_d = st_q;
        if (wr_en && in_cfg) begin
            for (int l = 0; l < 4; l++) begin
                if (bus_be[l]) st_d.cfg[{word_idx, 2'(l)}] = bus_wdata[8*l +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // write-1-to-clear strobes for the status words
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            clr_vec[s] = wr_en
                && (bus_addr == ADR_STAT_LO + 8'(4 * (s / 32)))
                && bus_be[(s % 32) / 8]
                && bus_wdata[s % 32];
        end
    end

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            irq_route_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
                .clk     (clk),
                .rst_n   (rst_n),
                .raw_i   (src_in[s]),
                .cfg_i   (st_q.cfg[s]),
                .clr_i   (clr_vec[s]),
                .latch_o (latch_vec[s]),
                .pend_o  (pend_vec[s])
            );
        end

        for (genvar k = 0; k < NOUT; k++) begin : g_route
            for (genvar s = 0; s < NSRC; s++) begin : g_bit
                assign routed[k][s] = pend_vec[s] && (st_q.cfg[s][2:0] == 3'(k));
            end
            assign line[k] = |routed[k];
        end

        for (genvar a = 0; a < NARB; a++) begin : g_arb
            assign arb_wr[a]  = wr_en && (bus_addr == arb_adr[a]) && bus_be[0];
            assign arb_ack[a] = rd_en && (bus_addr == arb_adr[a]);
            irq_route_arb #(.N(NSRC), .IW(IW)) u_arb (
                .clk     (clk),
                .rst_n   (rst_n),
                .req_i   (routed[a]),
                .wr_i    (arb_wr[a]),
                .wdata_i (bus_wdata[IW:0]),
                .ack_i   (arb_ack[a]),
                .valid_o (arb_valid[a]),
                .win_o   (arb_win[a]),
                .rot_o   (arb_rot[a])
            );
        end
    endgenerate

    assign irq_o = line[DST_NRM];
    assign fiq_o = line[DST_FST];
    assign aux_o = line[NOUT-1:DST_AUX0];

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (in_cfg) begin
            for (int l = 0; l < 4; l++) bus_rdata[8*l +: 8] = st_q.cfg[{word_idx, 2'(l)}];
        end
        for (int a = 0; a < NARB; a++) begin
            if (bus_addr == arb_adr[a]) begin
                bus_rdata[IW-1:0]  = arb_win[a];
                bus_rdata[ROT_BIT]   = arb_rot[a];
                bus_rdata[VALID_BIT] = arb_valid[a];
            end
        end
        for (int w = 0; w < NSTAT; w++) begin
            if (bus_addr == ADR_STAT_LO + 8'(4 * w)) bus_rdata = latch_vec[32*w +: 32];
        end
    end

    // R6: a raised normal or fast line always has a winner behind it
    a_r6_nrm_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> arb_valid[0]);
    a_r6_fst_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> arb_valid[1]);
endmodule

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NSRC-1:0] src_in = '0;
    logic        irq_o, fiq_o;
    logic [5:0]  aux_o;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_in(src_in),
        .irq_o(irq_o), .fiq_o(fiq_o), .aux_o(aux_o)
    );

    typedef struct packed {
        logic [5:0] src;
        logic [7:0] cfg;
        logic       lvl;
        logic [7:0] exp;   // {aux5..aux0, fast, normal}
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{6'd0,  8'h08, 1'b1, 8'h01},  // R3 R6 level to normal
        '{6'd63, 8'h09, 1'b1, 8'h02},  // R6 fast
        '{6'd17, 8'h0A, 1'b1, 8'h04},  // R6 aux0
        '{6'd33, 8'h0D, 1'b1, 8'h20},  // R6 aux3
        '{6'd40, 8'h0F, 1'b1, 8'h80},  // R6 aux5
        '{6'd5,  8'h01, 1'b1, 8'h00},  // R3 disabled
        '{6'd12, 8'h08, 1'b0, 8'h00},  // R3 input low
        '{6'd50, 8'h28, 1'b1, 8'h01},  // R4 rising edge
        '{6'd22, 8'h49, 1'b1, 8'h00},  // R4 falling mode ignores rise
        '{6'd9,  8'h68, 1'b1, 8'h01}   // R10 either edge
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic set_cfg(input int s, input logic [7:0] v);
        bwrite(8'h40 + 8'(s & ~3), 4'b1 << (s % 4), {24'd0, v} << (8 * (s % 4)));
    endtask

    task automatic clear_all();
        bwrite(8'h80, 4'hF, 32'hFFFF_FFFF);
        bwrite(8'h84, 4'hF, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        tick(3);
        rst_n = 1;
        tick(1);

        // R1 reset state
        chk("R1 lines", {24'd0, aux_o, fiq_o, irq_o}, 32'h0);
        bread(8'h40, rd); chk("R1 cfg lo", rd, 32'h0);
        bread(8'h7C, rd); chk("R1 cfg hi", rd, 32'h0);
        bread(8'h20, rd); chk("R1 prio nrm", rd, 32'h0);
        bread(8'h24, rd); chk("R1 prio fst", rd, 32'h0);
        bread(8'h80, rd); chk("R1 stat", rd, 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            set_cfg(VECS[i].src, VECS[i].cfg);
            src_in[VECS[i].src] = VECS[i].lvl;
            tick(4);
            chk("R3/R6/R4 vector", {24'd0, aux_o, fiq_o, irq_o}, {24'd0, VECS[i].exp});
            set_cfg(VECS[i].src, 8'h00);
            src_in = '0;
            tick(4);
            clear_all();
        end

        // R2 byte-lane write
        bwrite(8'h44, 4'b0100, 32'h115A_2233);
        bread(8'h44, rd); chk("R2 lane", rd, 32'h005A_0000);
        bwrite(8'h44, 4'b0100, 32'h0);

        // R3 timing: visible two clocks after input
        set_cfg(20, 8'h08);
        src_in[20] = 1;
        tick(1); chk("R3 not yet", {31'd0, irq_o}, 32'h0);
        tick(1); chk("R3 two clocks", {31'd0, irq_o}, 32'h1);
        src_in[20] = 0; tick(3);
        set_cfg(20, 8'h00);

        // R4 R9 latch while disabled, then enable
        set_cfg(34, 8'h20);
        src_in[34] = 1; tick(4);
        bread(8'h84, rd); chk("R4 latch disabled", rd, 32'h4);
        chk("R9 no output", {31'd0, irq_o}, 32'h0);
        set_cfg(34, 8'h28);
        chk("R9 enable late", {31'd0, irq_o}, 32'h1);
        // R5 write-0 keeps, write-1 clears
        bwrite(8'h84, 4'hF, 32'h0);
        bread(8'h84, rd); chk("R5 zero keeps", rd, 32'h4);
        bwrite(8'h84, 4'hF, 32'h4);
        bread(8'h84, rd); chk("R5 cleared", rd, 32'h0);
        chk("R5 line low", {31'd0, irq_o}, 32'h0);
        set_cfg(34, 8'h00); src_in = '0; tick(4); clear_all();

        // R4 falling edge
        set_cfg(2, 8'h48);
        src_in[2] = 1; tick(4);
        bread(8'h80, rd); chk("R4 no fall yet", rd, 32'h0);
        src_in[2] = 0; tick(4);
        bread(8'h80, rd); chk("R4 fall latched", rd, 32'h4);
        chk("R4 fall line", {31'd0, irq_o}, 32'h1);
        set_cfg(2, 8'h00); clear_all();

        // R10 both edges
        set_cfg(7, 8'h60);
        src_in[7] = 1; tick(4);
        bread(8'h80, rd); chk("R10 rise", rd, 32'h80);
        clear_all();
        src_in[7] = 0; tick(4);
        bread(8'h80, rd); chk("R10 fall", rd, 32'h80);
        set_cfg(7, 8'h00); clear_all();

        // R7 fixed priority and R8 rotation
        set_cfg(3, 8'h08); set_cfg(10, 8'h08); set_cfg(40, 8'h08);
        set_cfg(5, 8'h09);
        src_in[3] = 1; src_in[10] = 1; src_in[40] = 1; src_in[5] = 1;
        tick(3);
        bread(8'h20, rd); chk("R7 lowest", rd, 32'h83);
        bread(8'h20, rd); chk("R7 lowest again", rd, 32'h83);
        bread(8'h24, rd); chk("R7 fast reg", rd, 32'h85);
        bwrite(8'h20, 4'h1, 32'h7F);
        bread(8'h20, rd); chk("R8 first", rd, 32'hC3);
        bread(8'h20, rd); chk("R8 next", rd, 32'hCA);
        bread(8'h20, rd); chk("R8 third", rd, 32'hE8);
        bread(8'h20, rd); chk("R8 wrap", rd, 32'hC3);
        bwrite(8'h20, 4'h1, 32'h4A);
        bread(8'h20, rd); chk("R8 loaded ptr", rd, 32'hE8);
        bwrite(8'h20, 4'h1, 32'h00);
        bread(8'h20, rd); chk("R7 back to fixed", rd, 32'h83);
        src_in = '0; tick(3);
        bread(8'h20, rd); chk("R7 none pending", rd, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule